// File: doc/BRIEF.md
# Up-counting PWM timebase with compare-driven action logic

This block produces one PWM channel: a free-running up counter, two compare thresholds that raise and lower a pair of gate outputs, and a per-output software override. The counter runs from zero to a programmed period and then wraps to zero. Period and both compare thresholds are written into holding (shadow) registers. They become active only when the counter sits at zero, so a new setting never cuts a PWM cycle short. Several channels can be aligned in two ways. A common run enable holds every counter at zero until all channels are configured. A sync pulse reloads a counter with a programmed phase, and each channel emits a one-cycle sync pulse whenever its counter is at zero. Dead-band insertion happens after this block.

When the counter reaches threshold A, the shared action level goes high. When it reaches threshold B, the level goes low. Both outputs follow that level. A forced state can pull output A low and, separately, drive output B high. Commutation software can therefore park a half-bridge by writing the override without touching the downstream dead-band setup.

The timebase is controlled by a two-state machine. In `TB_HALT` the counter holds and the active registers track the shadows on every cycle. In `TB_RUN` the counter advances. The transition *start* (`TB_HALT`→`TB_RUN`) fires on a clock edge where `run_en` is high. The transition *stop* (`TB_RUN`→`TB_HALT`) fires on an edge where `run_en` is low. Otherwise the machine stays in its current state.

Top module: `pwm_chan`

## Requirements
- R1: After reset the counter reads 0, `out_a`, `out_b` and `sync_out` are low, the active period is `RST_PERIOD`, and both active thresholds are 0.
- R2: While the machine is in `TB_HALT` (`run_en` low), the counter holds its value and `sync_out` stays low. A sync pulse has no effect in this state.
- R3: In `TB_RUN` the counter steps by one per clock from 0 to the active period, then returns to 0. `sync_out` is high exactly in the cycles where the counter reads 0 while running.
- R4: A period write that arrives mid-cycle changes nothing until the counter next passes through 0. The cycle in progress ends at the old period.
- R5: Threshold writes take effect only from the next zero of the counter. In steady state with A < B ≤ period, both outputs are high exactly in the cycles where A < counter ≤ B. Each output therefore changes one clock after the counter equals the threshold.
- R6: If the counter equals both thresholds in the same cycle, the clear action wins. With A = B the outputs stay low for the whole cycle.
- R7: The override is written through `force_data`, where bit 0 forces `out_a` low and bit 1 forces `out_b` high. Each bit acts independently, starting in the cycle after the write. When a bit is cleared, its output returns to the compare-driven level.
- R8: When `phase_en` is high, a `sync_in` pulse in `TB_RUN` loads the stored phase value into the counter on the next clock. When `phase_en` is low, the pulse is ignored and counting continues.
- R9: While halted, written period and threshold values pass to the active registers without waiting for a zero, so the first running cycle already uses them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Global start; counter halted while low |
| phase_en | input | 1 | Allows `sync_in` to reload the counter |
| wr_period | input | 1 | Write `wr_data` into the period shadow |
| wr_cmp_a | input | 1 | Write `wr_data` into the threshold A shadow |
| wr_cmp_b | input | 1 | Write `wr_data` into the threshold B shadow |
| wr_phase | input | 1 | Write `wr_data` into the phase register |
| wr_data | input | CNT_W | Shared write data |
| wr_force | input | 1 | Write `force_data` into the override register |
| force_data | input | 2 | Bit 0: force A low; bit 1: force B high |
| sync_in | input | 1 | Phase reload request |
| sync_out | output | 1 | High while the running counter reads 0 |
| cnt | output | CNT_W | Current counter value |
| out_a | output | 1 | Gate output A |
| out_b | output | 1 | Gate output B |

## Verification
The wrap and set/clear properties assume the phase value never exceeds the active period. They also assume the period is at least 1, because a zero period would hold `sync_out` high on every cycle. The stimulus meets both conditions: it programs periods of 9 and 12 and a phase of 2. It writes shadows one at a time through the shared data bus, and it applies overrides and sync pulses as single-cycle strobes at known counter values. Expected waveforms are derived from the threshold window in R5 and are checked only over full cycles that begin after a zero-time load.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
    typedef enum logic {
        TB_HALT = 1'b0,
        TB_RUN  = 1'b1
    } tb_state_e;

    localparam int FRC_A_LOW  = 0;
    localparam int FRC_B_HIGH = 1;
    localparam int FRC_W      = 2;

    localparam int SH_PRD  = 0;
    localparam int SH_CMPA = 1;
    localparam int SH_CMPB = 2;
    localparam int SH_N    = 3;
endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
    parameter int           W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wr_val,
    input  logic         load,
    output logic [W-1:0] active
);
    logic [W-1:0] shadow_q;
    logic [W-1:0] active_q;

    // Shadow captures writes; active copies the shadow as it stood before the edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= RST_VAL;
            active_q <= RST_VAL;
        end else begin
            if (wr)   shadow_q <= wr_val;
            if (load) active_q <= shadow_q;
        end
    end

    assign active = active_q;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_chan_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic [W-1:0] prd_act,
    input  logic [W-1:0] phase_val,
    input  logic         phase_en,
    input  logic         sync_in,
    output logic [W-1:0] cnt,
    output logic         running,
    output logic         shadow_ld,
    output logic         sync_out
);
    tb_state_e    state_q, state_d;
    logic [W-1:0] cnt_q;
    logic         zero_evt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TB_HALT;
        else        state_q <= state_d;
    end

    // Transitions: start and stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TB_HALT: if (run_en)  state_d = TB_RUN;
            TB_RUN:  if (!run_en) state_d = TB_HALT;
            default: state_d = TB_HALT;
        endcase
    end

    // State outputs
    always_comb begin
        running   = 1'b0;
        unique case (state_q)
            TB_HALT: running = 1'b0;
            TB_RUN:  running = 1'b1;
            default: running = 1'b0;
        endcase
        zero_evt  = running && (cnt_q == '0);
        shadow_ld = !running || zero_evt;
        sync_out  = zero_evt;
    end

    // Counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (running) begin
            if (sync_in && phase_en)  cnt_q <= phase_val;
            else if (cnt_q >= prd_act) cnt_q <= '0;
            else                       cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/pwm_action.sv
module pwm_action
    import pwm_chan_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic [W-1:0]     cnt,
    input  logic [W-1:0]     cmpa_act,
    input  logic [W-1:0]     cmpb_act,
    input  logic             wr_force,
    input  logic [FRC_W-1:0] force_data,
    output logic             aq_lvl,
    output logic             out_a,
    output logic             out_b
);
    logic             hit_a, hit_b;
    logic             aq_q;
    logic [FRC_W-1:0] frc_q;

    assign hit_a = running && (cnt == cmpa_act);
    assign hit_b = running && (cnt == cmpb_act);

    // Clear outranks set when both thresholds match together.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     aq_q <= 1'b0;
        else if (hit_b) aq_q <= 1'b0;
        else if (hit_a) aq_q <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        frc_q <= '0;
        else if (wr_force) frc_q <= force_data;
    end

    assign aq_lvl = aq_q;
    assign out_a  = frc_q[FRC_A_LOW]  ? 1'b0 : aq_q;
    assign out_b  = frc_q[FRC_B_HIGH] ? 1'b1 : aq_q;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int RST_PERIOD = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             phase_en,
    input  logic             wr_period,
    input  logic             wr_cmp_a,
    input  logic             wr_cmp_b,
    input  logic             wr_phase,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             wr_force,
    input  logic [1:0]       force_data,
    input  logic             sync_in,
    output logic             sync_out,
    output logic [CNT_W-1:0] cnt,
    output logic             out_a,
    output logic             out_b
);
    logic [SH_N-1:0]  sh_wr;
    logic [CNT_W-1:0] sh_act [SH_N];
    logic [CNT_W-1:0] prd_act, cmpa_act, cmpb_act;
    logic [CNT_W-1:0] phase_q;
    logic             running, shadow_ld, aq_lvl;

    assign sh_wr[SH_PRD]  = wr_period;
    assign sh_wr[SH_CMPA] = wr_cmp_a;
    assign sh_wr[SH_CMPB] = wr_cmp_b;

    for (genvar g = 0; g < SH_N; g++) begin : g_sh
        localparam logic [CNT_W-1:0] RV = (g == SH_PRD) ? CNT_W'(RST_PERIOD) : '0;
        pwm_shadow_reg #(.W(CNT_W), .RST_VAL(RV)) u_sh (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (sh_wr[g]),
            .wr_val (wr_data),
            .load   (shadow_ld),
            .active (sh_act[g])
        );
    end

    assign prd_act  = sh_act[SH_PRD];
    assign cmpa_act = sh_act[SH_CMPA];
    assign cmpb_act = sh_act[SH_CMPB];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        phase_q <= '0;
        else if (wr_phase) phase_q <= wr_data;
    end

    pwm_timebase #(.W(CNT_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .prd_act   (prd_act),
        .phase_val (phase_q),
        .phase_en  (phase_en),
        .sync_in   (sync_in),
        .cnt       (cnt),
        .running   (running),
        .shadow_ld (shadow_ld),
        .sync_out  (sync_out)
    );

    pwm_action #(.W(CNT_W)) u_aq (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (running),
        .cnt        (cnt),
        .cmpa_act   (cmpa_act),
        .cmpb_act   (cmpb_act),
        .wr_force   (wr_force),
        .force_data (force_data),
        .aq_lvl     (aq_lvl),
        .out_a      (out_a),
        .out_b      (out_b)
    );
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         running,
    input logic         run_en,
    input logic         sync_in,
    input logic         phase_en,
    input logic [W-1:0] phase_q,
    input logic         wr_force,
    input logic [1:0]   force_data,
    input logic [W-1:0] cnt,
    input logic [W-1:0] prd_act,
    input logic [W-1:0] cmpa_act,
    input logic [W-1:0] cmpb_act,
    input logic         aq_lvl,
    input logic         sync_out,
    input logic         out_a,
    input logic         out_b
);
    p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> $stable(cnt));

    p_halt_no_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !sync_out);

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run_en && cnt == prd_act && !(sync_in && phase_en)) |=> (cnt == '0 && sync_out));

    p_shadow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt != '0) |=> ($stable(prd_act) && $stable(cmpa_act) && $stable(cmpb_act)));

    p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt == cmpa_act && cnt != cmpb_act) |=> aq_lvl);

    p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt == cmpb_act) |=> !aq_lvl);

    p_force_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_force && force_data[0]) |=> !out_a);

    p_force_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_force && force_data[1]) |=> out_b);

    p_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && sync_in && phase_en) |=> (cnt == $past(phase_q)));
endmodule

bind pwm_chan pwm_chan_chk #(.W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (running),
    .run_en     (run_en),
    .sync_in    (sync_in),
    .phase_en   (phase_en),
    .phase_q    (phase_q),
    .wr_force   (wr_force),
    .force_data (force_data),
    .cnt        (cnt),
    .prd_act    (prd_act),
    .cmpa_act   (cmpa_act),
    .cmpb_act   (cmpb_act),
    .aq_lvl     (aq_lvl),
    .sync_out   (sync_out),
    .out_a      (out_a),
    .out_b      (out_b)
);

// File: tb/sim_pwm_chan.sv
`timescale 1ns/1ps
module sim_pwm_chan;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         run_en, phase_en;
    logic         wr_period, wr_cmp_a, wr_cmp_b, wr_phase;
    logic [W-1:0] wr_data;
    logic         wr_force;
    logic [1:0]   force_data;
    logic         sync_in;
    logic         sync_out;
    logic [W-1:0] cnt;
    logic         out_a, out_b;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pwm_chan #(.CNT_W(W), .RST_PERIOD(15)) u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .phase_en(phase_en),
        .wr_period(wr_period), .wr_cmp_a(wr_cmp_a), .wr_cmp_b(wr_cmp_b),
        .wr_phase(wr_phase), .wr_data(wr_data), .wr_force(wr_force),
        .force_data(force_data), .sync_in(sync_in), .sync_out(sync_out),
        .cnt(cnt), .out_a(out_a), .out_b(out_b)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cnt=%0d)", req, act, exp, cnt);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wait_cnt(input int v);
        for (int i = 0; i < 64 && cnt != W'(v); i++) step();
    endtask

    // Single-cycle write on the shared bus: 0 period, 1 cmp A, 2 cmp B, 3 phase
    task automatic wr(input int sel, input int val);
        wr_data   = W'(val);
        wr_period = (sel == 0);
        wr_cmp_a  = (sel == 1);
        wr_cmp_b  = (sel == 2);
        wr_phase  = (sel == 3);
        step();
        wr_period = 0; wr_cmp_a = 0; wr_cmp_b = 0; wr_phase = 0;
    endtask

    task automatic wr_frc(input logic [1:0] v);
        force_data = v;
        wr_force   = 1;
        step();
        wr_force   = 0;
    endtask

    task automatic t_reset();
        chk(cnt == 0, "R1 cnt", int'(cnt), 0);
        chk(!out_a && !out_b, "R1 outputs", {out_a, out_b}, 0);
        chk(!sync_out, "R1 sync_out", sync_out, 0);
    endtask

    task automatic t_halt();
        wr(0, 9); wr(1, 2); wr(2, 6);
        sync_in = 1; phase_en = 1;
        wr(3, 4);
        step(); step();
        sync_in = 0; phase_en = 0;
        chk(cnt == 0, "R2 counter held", int'(cnt), 0);
        chk(!sync_out, "R2 no sync while halted", sync_out, 0);
    endtask

    task automatic t_count();
        run_en = 1;
        for (int i = 0; i < 8 && !sync_out; i++) step();
        for (int k = 0; k <= 9; k++) begin
            chk(cnt == W'(k), "R3/R9 count sequence", int'(cnt), k);
            chk(sync_out == (k == 0), "R3 sync_out", sync_out, int'(k == 0));
            step();
        end
        chk(cnt == 0, "R3 wrap at period", int'(cnt), 0);
    endtask

    task automatic t_compare();
        for (int k = 0; k <= 9; k++) begin
            bit e;
            e = (cnt > 2) && (cnt <= 6);
            chk(out_a == e, "R5 out_a window", out_a, int'(e));
            chk(out_b == e, "R5 out_b window", out_b, int'(e));
            step();
        end
    endtask

    task automatic t_shadow();
        wait_cnt(3);
        wr(2, 8);
        wr(0, 12);
        wait_cnt(7);
        chk(out_a == 0, "R5 old cmp B still active", out_a, 0);
        wait_cnt(9);
        step();
        chk(cnt == 0, "R4 old period ends cycle", int'(cnt), 0);
        for (int k = 0; k <= 12; k++) begin
            bit e;
            e = (cnt > 2) && (cnt <= 8);
            chk(cnt == W'(k), "R4 new period count", int'(cnt), k);
            chk(out_a == e, "R5 new cmp B window", out_a, int'(e));
            step();
        end
        chk(cnt == 0, "R4 wrap at new period", int'(cnt), 0);
    endtask

    task automatic t_equal();
        wr(1, 5); wr(2, 5);
        wait_cnt(0);
        for (int k = 0; k <= 12; k++) begin
            chk(!out_a && !out_b, "R6 clear wins on equal thresholds", {out_a, out_b}, 0);
            step();
        end
    endtask

    task automatic t_force();
        wr(1, 2); wr(2, 8);
        wait_cnt(0);
        wait_cnt(4);
        chk(out_a == 1, "R7 before force", out_a, 1);
        wr_frc(2'b01);
        chk(out_a == 0, "R7 A forced low next cycle", out_a, 0);
        chk(out_b == 1, "R7 B unaffected", out_b, 1);
        wait_cnt(10);
        chk(out_b == 0, "R7 B follows compare", out_b, 0);
        wr_frc(2'b10);
        chk(out_b == 1, "R7 B forced high", out_b, 1);
        chk(out_a == 0, "R7 A released low region", out_a, 0);
        wr_frc(2'b00);
        wait_cnt(5);
        chk(out_a && out_b, "R7 release returns to compare", {out_a, out_b}, 3);
        wait_cnt(10);
        chk(!out_a && !out_b, "R7 release low region", {out_a, out_b}, 0);
    endtask

    task automatic t_phase();
        wr(3, 2);
        wait_cnt(7);
        phase_en = 0; sync_in = 1;
        step();
        sync_in = 0;
        chk(cnt == 8, "R8 sync ignored when disabled", int'(cnt), 8);
        wait_cnt(5);
        phase_en = 1; sync_in = 1;
        step();
        sync_in = 0; phase_en = 0;
        chk(cnt == 2, "R8 phase loaded", int'(cnt), 2);
        step();
        chk(cnt == 3, "R8 counting resumes", int'(cnt), 3);
    endtask

    initial begin
        rst_n = 0; run_en = 0; phase_en = 0;
        wr_period = 0; wr_cmp_a = 0; wr_cmp_b = 0; wr_phase = 0;
        wr_data = '0; wr_force = 0; force_data = '0; sync_in = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        t_reset();
        t_halt();
        t_count();
        t_compare();
        t_shadow();
        t_equal();
        t_force();
        t_phase();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule